// File: doc/BRIEF.md
# GPIO Interrupt Style Detector

This block watches a bank of general-purpose input pins and raises a per-pin interrupt when the condition chosen for that pin occurs. Each pin has its own trigger style: a high or low level, a rising or falling edge, or any change. Pins are passed through a multi-flop synchronizer before detection. A detected condition sets a sticky pending bit, and that bit drives the pin's interrupt output directly.

Software programs the trigger styles through a small register port. The styles are packed three bits per pin into a set of style registers, each holding one group of pins. Software reads and acknowledges pending bits through a status register: writing a one clears a bit. For level styles, a pending bit cannot be dropped while its level is still present. The pin count, the group size, the synchronizer depth and the bus widths are all parameters.

Top module: `gpio_irq_style_det`

## Requirements
- R1: A pin's 3-bit style code selects its trigger. 0 is level high, 1 is level low, 2 is rising edge, 3 is falling edge and 4 is any edge. Codes 5, 6 and 7 disable the pin, so its pending bit is never set.
- R2: Style register k (address k, for k below the number of groups) holds the pins k*8 to k*8+7. Pin p uses bits 3*(p mod 8)+2 down to 3*(p mod 8). A write replaces the whole register, and bits 24 and above always read as zero.
- R3: The status register sits at the address equal to the group count (2 by default), and bit n is pin n. Writing 1 to bit n clears that bit, and writing 0 leaves it unchanged. A read returns the pending bits, with zeros above them.
- R4: For a level style, a pending bit stays set while its level is present, even during a clear write. It can be cleared once the level is gone.
- R5: An edge event leaves its pending bit set until it is cleared. If an edge and a clear of the same bit land in the same cycle, the bit stays set.
- R6: A pin change reaches its pending bit and interrupt output three clock edges after it is applied: two synchronizer edges plus the status register edge.
- R7: Reset sets every style field to 0 and clears every pending bit, so all interrupt outputs are low.
- R8: irq_o[n] equals pending bit n at all times.
- R9: The following sequence leaves no pending bit behind, and the new edge style then reacts only to a fresh edge:
  - set the field to 0 while the pin is low;
  - clear the status bit;
  - write an edge style.
- R10: Addresses above the status register read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr (combinational) |
| irq_o | output | NUM_PINS | Per-pin interrupt, equal to pending bits |

## Verification
The bench builds the block with its defaults: 16 pins in groups of 8, a two-stage synchronizer, 32-bit data and a 2-bit address. These defaults give two style registers, the status register at address 2, and one unmapped address at 3, so the group split, the field offsets within a register and the dead address are all reachable. Random writes of full 32-bit words to the style registers reach all eight codes on every pin, including the disabled ones. Random pin activity then exercises each style against a model of the pending bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int STYLE_W = 3;

   localparam logic [STYLE_W-1:0] STY_LVL_HI = 3'd0;
   localparam logic [STYLE_W-1:0] STY_LVL_LO = 3'd1;
   localparam logic [STYLE_W-1:0] STY_RISE   = 3'd2;
   localparam logic [STYLE_W-1:0] STY_FALL   = 3'd3;
   localparam logic [STYLE_W-1:0] STY_ANY    = 3'd4;

   // Trigger condition for one pin given its style, current and previous sample
   function automatic logic style_hit(input logic [STYLE_W-1:0] sty,
                                      input logic cur, input logic prev);
      logic hit;
      case (sty)
         STY_LVL_HI: hit = cur;
         STY_LVL_LO: hit = !cur;
         STY_RISE:   hit = cur && !prev;
         STY_FALL:   hit = !cur && prev;
         STY_ANY:    hit = cur ^ prev;
         default:    hit = 1'b0;
      endcase
      return hit;
   endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;
   logic [W-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign cur_o  = chain_q[STAGES-1];
   assign prev_o = prev_q;

   // The previous sample is the current sample one edge late
   AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> prev_o == $past(cur_o)); // R6
endmodule

// File: rtl/gpio_irq_pin_det.sv
module gpio_irq_pin_det
   import gpio_irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STYLE_W-1:0] style_i,
   input  logic               cur_i,
   input  logic               prev_i,
   input  logic               clr_i,
   output logic               status_o
);
   logic hit;
   logic status_q;

   assign hit = style_hit(style_i, cur_i, prev_i);

   // Set has priority over a write-one clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     status_q <= 1'b0;
      else if (hit)   status_q <= 1'b1;
      else if (clr_i) status_q <= 1'b0;
   end

   assign status_o = status_q;

   AST_LEVEL_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (style_i == STY_LVL_HI && cur_i) |=> status_q); // R4
   AST_LEVEL_LO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (style_i == STY_LVL_LO && !cur_i) |=> status_q); // R4
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !clr_i) |=> status_q); // R5
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (style_i > STY_ANY && !status_q) |=> !status_q); // R1
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS      = 16,
   parameter int PINS_PER_BANK = 8,
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [NUM_PINS-1:0]          status_i,
   output logic [DATA_W-1:0]            rdata,
   output logic [NUM_PINS*STYLE_W-1:0]  style_o,
   output logic [NUM_PINS-1:0]          clr_o
);
   localparam int NUM_BANKS  = NUM_PINS / PINS_PER_BANK;
   localparam int FIELD_SPAN = PINS_PER_BANK * STYLE_W;
   localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_BANKS);

   logic [NUM_BANKS-1:0][FIELD_SPAN-1:0] type_q;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) type_q[b] <= '0;
         else if (wr_en && addr == ADDR_W'(b)) type_q[b] <= wdata[FIELD_SPAN-1:0];
      end
      assign style_o[b*FIELD_SPAN +: FIELD_SPAN] = type_q[b];

      AST_TYPE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(b)) |=> type_q[b] == $past(wdata[FIELD_SPAN-1:0])); // R2
   end

   assign clr_o = (wr_en && addr == STATUS_ADDR) ? wdata[NUM_PINS-1:0] : '0;

   always_comb begin
      rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (addr == ADDR_W'(b)) rdata[FIELD_SPAN-1:0] = type_q[b];
      end
      if (addr == STATUS_ADDR) rdata[NUM_PINS-1:0] = status_i;
   end

   AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr > STATUS_ADDR) |=> $stable(style_o)); // R10
endmodule

// File: rtl/gpio_irq_style_det.sv
module gpio_irq_style_det
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS      = 16,
   parameter int PINS_PER_BANK = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic [NUM_PINS-1:0] irq_o
);
   localparam int NUM_BANKS = NUM_PINS / PINS_PER_BANK;

   if (NUM_PINS % PINS_PER_BANK != 0) begin : g_bad_bank
      $error("gpio_irq_style_det: NUM_PINS must be a multiple of PINS_PER_BANK");
   end
   if (PINS_PER_BANK * STYLE_W > DATA_W) begin : g_bad_span
      $error("gpio_irq_style_det: style fields of one bank exceed DATA_W");
   end
   if (NUM_PINS > DATA_W) begin : g_bad_status
      $error("gpio_irq_style_det: status register wider than DATA_W");
   end
   if (NUM_BANKS + 1 > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_irq_style_det: ADDR_W too small for register map");
   end

   logic [NUM_PINS-1:0]         cur, prev, clr, status;
   logic [NUM_PINS*STYLE_W-1:0] style;

   gpio_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_i), .cur_o(cur), .prev_o(prev)
   );

   gpio_irq_regs #(
      .NUM_PINS(NUM_PINS), .PINS_PER_BANK(PINS_PER_BANK),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .status_i(status), .rdata(rdata), .style_o(style), .clr_o(clr)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      gpio_irq_pin_det u_det (
         .clk(clk), .rst_n(rst_n),
         .style_i(style[p*STYLE_W +: STYLE_W]),
         .cur_i(cur[p]), .prev_i(prev[p]), .clr_i(clr[p]),
         .status_o(status[p])
      );
   end

   assign irq_o = status;

   // A bit written as zero in a clear write keeps its pending state
   AST_W1C_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(NUM_BANKS) && irq_o[0] && !wdata[0]) |=> irq_o[0]); // R3
endmodule

// File: tb/gpio_irq_style_det_tb.sv
`timescale 1ns/1ps
module gpio_irq_style_det_tb;
   localparam int NP = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NP-1:0] pin_i = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NP-1:0] irq_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   gpio_irq_style_det u_dut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
   );

   // ---------------- bench model built from the requirements ----------------
   logic [NP-1:0] m_s1, m_s2, m_prev, m_stat;
   logic [23:0]   m_type [2];

   function automatic logic exp_hit(input logic [2:0] s, input logic c, input logic p);
      if (s == 3'd0) return c;
      if (s == 3'd1) return !c;
      if (s == 3'd2) return c & !p;
      if (s == 3'd3) return !c & p;
      if (s == 3'd4) return c != p;
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_read(input logic [1:0] a);
      if (a == 2'd0) return {8'h0, m_type[0]};
      if (a == 2'd1) return {8'h0, m_type[1]};
      if (a == 2'd2) return {16'h0, m_stat};
      return 32'h0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stat <= '0;
         m_type[0] <= '0; m_type[1] <= '0;
      end else begin
         logic [NP-1:0] nxt;
         logic [NP-1:0] clr;
         clr = (wr_en && addr == 2'd2) ? wdata[NP-1:0] : '0;
         for (int p = 0; p < NP; p++) begin
            logic [2:0] s;
            s = m_type[p / 8][(p % 8) * 3 +: 3];
            nxt[p] = exp_hit(s, m_s2[p], m_prev[p]) | (m_stat[p] & !clr[p]);
         end
         m_stat <= nxt;
         m_s1 <= pin_i; m_s2 <= m_s1; m_prev <= m_s2;
         if (wr_en && addr == 2'd0) m_type[0] <= wdata[23:0];
         if (wr_en && addr == 2'd1) m_type[1] <= wdata[23:0];
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
      addr = a;
      #1;
      chk(tag, rdata, exp);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7: reset state
      rd_chk(2'd0, 32'h0, "R7 style bank0 after reset");
      rd_chk(2'd1, 32'h0, "R7 style bank1 after reset");
      rd_chk(2'd2, 32'h0, "R7 status after reset");
      chk("R7 irq after reset", 32'(irq_o), 32'h0);

      // R2: register layout and width
      wr(2'd0, 32'hFFFF_FFFF);
      rd_chk(2'd0, 32'h00FF_FFFF, "R2 bank0 upper bits read zero");
      wr(2'd1, 32'h1234_5678);
      rd_chk(2'd1, 32'h0034_5678, "R2 bank1 readback");
      // R10: unmapped address
      wr(2'd3, 32'hFFFF_FFFF);
      rd_chk(2'd3, 32'h0, "R10 unmapped read");
      rd_chk(2'd0, 32'h00FF_FFFF, "R10 bank0 untouched");
      rd_chk(2'd1, 32'h0034_5678, "R10 bank1 untouched");
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h0);
      wr(2'd2, 32'h0000_FFFF);
      rd_chk(2'd2, 32'h0, "R3 status cleared by ones");

      // R6: latency on pin 5, rising style
      wr(2'd0, 32'(2) << 15);
      pin_i[5] = 1'b1;
      @(negedge clk); #1 chk("R6 one edge after", 32'(irq_o[5]), 32'h0);
      @(negedge clk); #1 chk("R6 two edges after", 32'(irq_o[5]), 32'h0);
      @(negedge clk); #1 chk("R6 three edges after", 32'(irq_o[5]), 32'h1);
      rd_chk(2'd2, 32'h0000_0020, "R8 status read matches irq");
      chk("R8 irq equals status", 32'(irq_o), 32'h0000_0020);

      // R5 sticky, R3 zero write keeps
      repeat (4) @(negedge clk);
      pin_i[5] = 1'b0;
      repeat (4) @(negedge clk);
      #1 chk("R5 sticky after pin falls", 32'(irq_o[5]), 32'h1);
      wr(2'd2, 32'h0000_FFDF);
      #1 chk("R3 zero bit keeps pending", 32'(irq_o[5]), 32'h1);
      wr(2'd2, 32'h0000_0020);
      #1 chk("R3 one bit clears", 32'(irq_o[5]), 32'h0);

      // R5: clear and edge in the same cycle
      pin_i[5] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; addr = 2'd2; wdata = 32'h20;
      @(negedge clk);
      wr_en = 1'b0;
      #1 chk("R5 edge wins over clear", 32'(irq_o[5]), 32'h1);
      wr(2'd2, 32'h20);
      repeat (3) @(negedge clk);
      #1 chk("R5 no event while high", 32'(irq_o[5]), 32'h0);
      pin_i[5] = 1'b0;

      // R4: level low on pin 9
      wr(2'd1, 32'(1) << 3);
      repeat (2) @(negedge clk);
      #1 chk("R4 level low sets", 32'(irq_o[9]), 32'h1);
      wr(2'd2, 32'h0200);
      #1 chk("R4 clear refused while level", 32'(irq_o[9]), 32'h1);
      pin_i[9] = 1'b1;
      repeat (3) @(negedge clk);
      wr(2'd2, 32'h0200);
      #1 chk("R4 clear after level gone", 32'(irq_o[9]), 32'h0);
      wr(2'd1, 32'h0);
      pin_i[9] = 1'b0;

      // R1: falling on pin0, any on pin1, disabled on pin2
      repeat (4) @(negedge clk);
      wr(2'd0, 32'(3) | (32'(4) << 3) | (32'(6) << 6));
      wr(2'd2, 32'hFFFF);
      rd_chk(2'd2, 32'h0, "R1 status clean before stimulus");
      pin_i[2:0] = 3'b111;
      repeat (4) @(negedge clk);
      #1 chk("R1 rising pattern", 32'(irq_o[2:0]), 32'h2);
      wr(2'd2, 32'hFFFF);
      pin_i[2:0] = 3'b000;
      repeat (4) @(negedge clk);
      #1 chk("R1 falling pattern", 32'(irq_o[2:0]), 32'h3);
      wr(2'd2, 32'hFFFF);

      // R9: style change sequence on pin 4
      wr(2'd0, 32'(1) << 12);
      repeat (2) @(negedge clk);
      #1 chk("R9 pending under old style", 32'(irq_o[4]), 32'h1);
      wr(2'd0, 32'h0);
      wr(2'd2, 32'h10);
      wr(2'd0, 32'(2) << 12);
      repeat (4) @(negedge clk);
      #1 chk("R9 no stale pending", 32'(irq_o[4]), 32'h0);
      pin_i[4] = 1'b1;
      repeat (3) @(negedge clk);
      #1 chk("R9 new style reacts", 32'(irq_o[4]), 32'h1);

      // Random phase against the model
      for (int i = 0; i < 3000; i++) begin
         int op;
         @(negedge clk);
         op = $urandom % 10;
         pin_i = NP'($urandom);
         wr_en = (op < 4);
         addr = 2'($urandom);
         wdata = (op < 2) ? $urandom : ($urandom & $urandom);
         #1;
         chk("R1 R8 random irq", 32'(irq_o), 32'(m_stat));
         chk("R2 R3 random read", rdata, exp_read(addr));
      end
      wr_en = 1'b0;
      finish_run();
   end
endmodule